// File: doc/BRIEF.md
# Multi-Mode Video Pixel Serializer

This block turns pairs of video-memory bytes into a stream of 5-bit colour codes, sixteen pixel slots per character period. An upstream raster controller offers one character record at a time. The record carries the controller's memory address, the raster row, the character column, a display-enable flag and the two sync flags. The block computes the two byte addresses for that character on combinational outputs. The requester returns the two bytes in the same cycle, on the data inputs, as part of the same record.

Each accepted character becomes sixteen output pixels.
- In display time, each pixel is a pen index unpacked from the byte according to the line's screen mode, then looked up in sixteen pen colour codes.
- In border time, every slot carries the border colour code.
- During horizontal or vertical sync, every slot carries a fixed blank code and the blank flag is raised.

The screen mode is taken only on a character marked as the start of a line. It then holds for every later character until the next line start.

Both the character input and the pixel output are valid/ready streams. A character is accepted on a clock edge where `chr_valid` and `chr_ready` are both high. `chr_ready` is high when no character is in flight, or when the last pixel of the current character is being accepted in that cycle, which allows back-to-back characters with no bubble. A pixel is consumed on an edge where `pix_valid` and `pix_ready` are both high. While `pix_ready` is low, the current pixel slot holds and no new character is accepted.

Top module: `vid_pixel_serializer`

## Requirements
- R1: After reset, `pix_valid` is 0, `chr_ready` is 1, and the held line mode is 0.
- R2: The first byte address is P + L. P is ((`chr_ma` << 2) AND 0xF000) + `chr_ras` × 0x800, taken as 16 bits. L is (((`chr_ma` × 2) AND 0x7FF) + 2 × `chr_col`) AND 0x7FF.
- R3: The second byte address uses the same P and the 11-bit offset L + 1 wrapped to 11 bits; bits 15..11 equal those of the first address.
- R4: In modes 0 and 3, slots 0–3 of a byte show the pen {b1,b5,b3,b7} and slots 4–7 show the pen {b0,b4,b2,b6}, written MSB first, so b7 is pen bit 0.
- R5: In mode 1, slot pair j (j = 0..3) of a byte shows the pen {b(3−j), b(7−j)}, MSB first.
- R6: In mode 2, slot q (q = 0..7) of a byte shows the pen b(7−q), a 1-bit pen.
- R7: With `chr_disp_en` = 0 and both sync flags low, all 16 slots carry `border_code` and `pix_blank` = 0.
- R8: With either sync flag high, all 16 slots carry BLANK_CODE (default 20) and `pix_blank` = 1, whatever `chr_disp_en` is.
- R9: The mode is sampled from `scr_mode` only on an accepted character with `chr_line_start` = 1, and it is held for all later characters.
- R10: Each character gives exactly 16 pixels: slots 0–7 come from `vram_data_a`, slots 8–15 from `vram_data_b`. A pixel holds while `pix_ready` = 0. `chr_ready` is 0 while a character is in flight, except in the cycle its last pixel is being accepted.
- R11: In display time, a pixel with pen p carries `pen_codes[5p+4:5p]`, and `pix_blank` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | Character record offered |
| chr_ready | output | 1 | Character record can be taken |
| chr_line_start | input | 1 | Record is the first character of a line |
| chr_disp_en | input | 1 | Display-enable from the raster controller |
| chr_hsync | input | 1 | Horizontal sync active |
| chr_vsync | input | 1 | Vertical sync active |
| chr_ma | input | 14 | Controller memory address |
| chr_ras | input | 3 | Raster row within the character |
| chr_col | input | 7 | Character column within the line |
| vram_addr_a | output | 16 | Address of the first byte |
| vram_addr_b | output | 16 | Address of the second byte |
| vram_data_a | input | 8 | First byte, valid with the record |
| vram_data_b | input | 8 | Second byte, valid with the record |
| scr_mode | input | 2 | Screen mode, used on line start |
| pen_codes | input | 80 | Sixteen 5-bit pen colour codes, pen p at bits 5p+4..5p |
| border_code | input | 5 | Border colour code |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Pixel consumer ready |
| pix_color | output | 5 | Colour code of the pixel |
| pix_blank | output | 1 | Pixel falls in sync time |

## Verification
A wrong slot counter shows up as a wrong pixel, either within one character or at the seam where the second byte takes over at slot 8. It can also show up as `chr_ready` rising too early or too late relative to the sixteenth accepted pixel. A line-mode register that updates on the wrong character only shows up at the first display pixel of the next character that lacks a line-start mark, as a pen unpacked in the wrong layout. Address faults are visible in the same cycle the record is offered, before any handshake. Random stalls on `pix_ready` make any slot that advances without a handshake visible as a skipped or repeated pixel.

// File: rtl/vps_pkg.sv
package vps_pkg;
  typedef enum logic [1:0] {
    SLOT_BLANK   = 2'd0,
    SLOT_BORDER  = 2'd1,
    SLOT_DISPLAY = 2'd2
  } slot_kind_t;
endpackage

// File: rtl/vps_addr_gen.sv
module vps_addr_gen #(
  parameter int MA_W   = 14,
  parameter int RAS_W  = 3,
  parameter int COL_W  = 7,
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 11,
  parameter int BYTES  = 2
) (
  input  logic [MA_W-1:0]              ma,
  input  logic [RAS_W-1:0]             ras,
  input  logic [COL_W-1:0]             col,
  output logic [BYTES-1:0][ADDR_W-1:0] addr
);
  localparam int PAGE_LSB = OFF_W + 1;
  localparam logic [ADDR_W-1:0] PAGE_MASK =
    ~((ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] page_base;
  logic [OFF_W-1:0]  line_off;

  always_comb begin
    page_base = (ADDR_W'({ma, 2'b00}) & PAGE_MASK) + (ADDR_W'(ras) << OFF_W);
    line_off  = OFF_W'({ma, 1'b0}) + OFF_W'(col) * OFF_W'(BYTES);
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [OFF_W-1:0] off_b;
    assign off_b   = line_off + OFF_W'(b);
    assign addr[b] = page_base + ADDR_W'(off_b);
  end

  always_comb begin
    AST_PAIR_SAME_PAGE: assert (addr[1][ADDR_W-1:OFF_W] == addr[0][ADDR_W-1:OFF_W])
      else $error("byte addresses differ above offset"); // R3
  end
endmodule

// File: rtl/vps_pen_unpack.sv
module vps_pen_unpack #(
  parameter int PEN_W = 4
) (
  input  logic [1:0]       mode,
  input  logic [7:0]       byte_a,
  input  logic [7:0]       byte_b,
  input  logic [3:0]       slot,
  output logic [PEN_W-1:0] pen
);
  logic [7:0] src;
  logic [2:0] q;
  logic [1:0] j;

  always_comb begin
    src = slot[3] ? byte_b : byte_a;
    q   = slot[2:0];
    j   = q[2:1];
    unique case (mode)
      2'd2:    pen = PEN_W'(src[3'd7 - q]);
      2'd1:    pen = PEN_W'({src[3'd3 - {1'b0, j}], src[3'd7 - {1'b0, j}]});
      default: pen = q[2] ? PEN_W'({src[0], src[4], src[2], src[6]})
                          : PEN_W'({src[1], src[5], src[3], src[7]});
    endcase
  end
endmodule

// File: rtl/vps_char_seq.sv
module vps_char_seq
  import vps_pkg::*;
#(
  parameter int PIX_N = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_line_start,
  input  logic [1:0]               in_mode,
  input  slot_kind_t               in_kind,
  input  logic [7:0]               in_byte_a,
  input  logic [7:0]               in_byte_b,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2(PIX_N)-1:0] slot,
  output slot_kind_t               kind,
  output logic [1:0]               mode,
  output logic [7:0]               byte_a,
  output logic [7:0]               byte_b
);
  localparam int SLOT_W = $clog2(PIX_N);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PIX_N - 1);

  logic busy;
  logic accept;

  assign in_ready  = !busy || (out_ready && slot == LAST);
  assign accept    = in_valid && in_ready;
  assign out_valid = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= '0;
      kind   <= SLOT_BLANK;
      mode   <= 2'd0;
      byte_a <= '0;
      byte_b <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      slot   <= '0;
      kind   <= in_kind;
      byte_a <= in_byte_a;
      byte_b <= in_byte_b;
      if (in_line_start) mode <= in_mode;
    end else if (busy && out_ready) begin
      if (slot == LAST) busy <= 1'b0;
      slot <= slot + SLOT_W'(1);
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(slot)); // R10
  AST_START_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid && slot == '0); // R10
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_line_start |=> $stable(mode)); // R9
  AST_MODE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_line_start |=> mode == $past(in_mode)); // R9
endmodule

// File: rtl/vid_pixel_serializer.sv
module vid_pixel_serializer
  import vps_pkg::*;
#(
  parameter int MA_W       = 14,
  parameter int RAS_W      = 3,
  parameter int COL_W      = 7,
  parameter int ADDR_W     = 16,
  parameter int CODE_W     = 5,
  parameter int PENS       = 16,
  parameter int BLANK_CODE = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chr_valid,
  output logic                   chr_ready,
  input  logic                   chr_line_start,
  input  logic                   chr_disp_en,
  input  logic                   chr_hsync,
  input  logic                   chr_vsync,
  input  logic [MA_W-1:0]        chr_ma,
  input  logic [RAS_W-1:0]       chr_ras,
  input  logic [COL_W-1:0]       chr_col,
  output logic [ADDR_W-1:0]      vram_addr_a,
  output logic [ADDR_W-1:0]      vram_addr_b,
  input  logic [7:0]             vram_data_a,
  input  logic [7:0]             vram_data_b,
  input  logic [1:0]             scr_mode,
  input  logic [PENS*CODE_W-1:0] pen_codes,
  input  logic [CODE_W-1:0]      border_code,
  output logic                   pix_valid,
  input  logic                   pix_ready,
  output logic [CODE_W-1:0]      pix_color,
  output logic                   pix_blank
);
  localparam int PEN_W  = $clog2(PENS);
  localparam int PIX_N  = 16;
  localparam int SLOT_W = $clog2(PIX_N);

  logic [1:0][ADDR_W-1:0] addr_pair;
  slot_kind_t             in_kind, cur_kind;
  logic [SLOT_W-1:0]      slot;
  logic [1:0]             cur_mode;
  logic [7:0]             cur_a, cur_b;
  logic [PEN_W-1:0]       pen;

  vps_addr_gen #(
    .MA_W(MA_W), .RAS_W(RAS_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .OFF_W(11), .BYTES(2)
  ) u_addr (
    .ma(chr_ma), .ras(chr_ras), .col(chr_col), .addr(addr_pair)
  );
  assign vram_addr_a = addr_pair[0];
  assign vram_addr_b = addr_pair[1];

  always_comb begin
    if (chr_hsync || chr_vsync) in_kind = SLOT_BLANK;
    else if (!chr_disp_en)      in_kind = SLOT_BORDER;
    else                        in_kind = SLOT_DISPLAY;
  end

  vps_char_seq #(.PIX_N(PIX_N)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(chr_valid), .in_ready(chr_ready),
    .in_line_start(chr_line_start), .in_mode(scr_mode), .in_kind(in_kind),
    .in_byte_a(vram_data_a), .in_byte_b(vram_data_b),
    .out_valid(pix_valid), .out_ready(pix_ready),
    .slot(slot), .kind(cur_kind), .mode(cur_mode),
    .byte_a(cur_a), .byte_b(cur_b)
  );

  vps_pen_unpack #(.PEN_W(PEN_W)) u_unpack (
    .mode(cur_mode), .byte_a(cur_a), .byte_b(cur_b), .slot(slot), .pen(pen)
  );

  always_comb begin
    pix_blank = 1'b0;
    unique case (cur_kind)
      SLOT_BLANK: begin
        pix_color = CODE_W'(BLANK_CODE);
        pix_blank = 1'b1;
      end
      SLOT_BORDER: pix_color = border_code;
      default:     pix_color = pen_codes[int'(pen)*CODE_W +: CODE_W];
    endcase
  end

  AST_BLANK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_blank |-> pix_color == CODE_W'(BLANK_CODE)); // R8
  AST_READY_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && chr_ready |=> !chr_ready || pix_ready); // R10
endmodule

// File: tb/vid_pixel_serializer_bench.sv
module vid_pixel_serializer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        chr_valid = 0, chr_ready, chr_line_start = 0;
  logic        chr_disp_en = 0, chr_hsync = 0, chr_vsync = 0;
  logic [13:0] chr_ma = 0;
  logic [2:0]  chr_ras = 0;
  logic [6:0]  chr_col = 0;
  logic [15:0] vram_addr_a, vram_addr_b;
  logic [7:0]  vram_data_a = 0, vram_data_b = 0;
  logic [1:0]  scr_mode = 0;
  logic [79:0] pen_codes = 0;
  logic [4:0]  border_code = 0;
  logic        pix_valid, pix_ready = 0, pix_blank;
  logic [4:0]  pix_color;

  vid_pixel_serializer u_vid_pixel_serializer (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_ready(chr_ready),
    .chr_line_start(chr_line_start), .chr_disp_en(chr_disp_en),
    .chr_hsync(chr_hsync), .chr_vsync(chr_vsync), .chr_ma(chr_ma),
    .chr_ras(chr_ras), .chr_col(chr_col), .vram_addr_a(vram_addr_a),
    .vram_addr_b(vram_addr_b), .vram_data_a(vram_data_a),
    .vram_data_b(vram_data_b), .scr_mode(scr_mode), .pen_codes(pen_codes),
    .border_code(border_code), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_color(pix_color), .pix_blank(pix_blank)
  );

  int checks = 0;
  int errors = 0;
  logic [1:0] line_mode = 2'd0;
  logic [4:0] pens [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(logic [13:0] ma, logic [2:0] ras,
                                            logic [6:0] col, int b);
    logic [15:0] hi;
    logic [10:0] lo;
    hi = (({2'b00, ma} << 2) & 16'hF000) + ({13'd0, ras} * 16'h0800);
    lo = 11'(({2'b00, ma} * 16'd2) & 16'h07FF) + 11'({col, 1'b0}) + 11'(b);
    return hi + {5'd0, lo};
  endfunction

  function automatic int exp_pen(logic [1:0] md, logic [7:0] v, int q);
    int j;
    case (md)
      2'd2: return int'(v[7 - q]);
      2'd1: begin
        j = q / 2;
        return int'(v[7 - j]) + 2 * int'(v[3 - j]);
      end
      default:
        if (q < 4) return int'(v[7]) + 2*int'(v[3]) + 4*int'(v[5]) + 8*int'(v[1]);
        else       return int'(v[6]) + 2*int'(v[2]) + 4*int'(v[4]) + 8*int'(v[0]);
    endcase
  endfunction

  task automatic load_pens();
    for (int p = 0; p < 16; p++) begin
      pens[p] = 5'($urandom % 27);
      pen_codes[p*5 +: 5] = pens[p];
    end
    border_code = 5'($urandom % 27);
  endtask

  task automatic run_char(input bit ls, input logic [1:0] md, input bit de,
                          input bit hs, input bit vs, input logic [7:0] ba,
                          input logic [7:0] bb, input logic [13:0] ma,
                          input logic [2:0] ras, input logic [6:0] col,
                          input int stall_pct);
    int k;
    int pen;
    int ex;
    string tag;
    logic [7:0] v;
    if (ls) line_mode = md;
    chr_valid = 1; chr_line_start = ls; scr_mode = md; chr_disp_en = de;
    chr_hsync = hs; chr_vsync = vs; vram_data_a = ba; vram_data_b = bb;
    chr_ma = ma; chr_ras = ras; chr_col = col;
    #1;
    chk(vram_addr_a == exp_addr(ma, ras, col, 0), "R2", vram_addr_a, exp_addr(ma, ras, col, 0));
    chk(vram_addr_b == exp_addr(ma, ras, col, 1), "R3", vram_addr_b, exp_addr(ma, ras, col, 1));
    chk(chr_ready == 1'b1, "R10 idle ready", chr_ready, 1);
    @(posedge clk); @(negedge clk);
    chr_valid = 0;
    k = 0;
    while (k < 16) begin
      pix_ready = (($urandom % 100) >= 32'(stall_pct));
      #1;
      chk(pix_valid == 1'b1, "R10 valid", pix_valid, 1);
      if (pix_ready) begin
        v = (k < 8) ? ba : bb;
        if (hs || vs) begin
          tag = "R8"; ex = 20;
        end else if (!de) begin
          tag = "R7"; ex = int'(border_code);
        end else begin
          pen = exp_pen(line_mode, v, k % 8);
          ex = int'(pens[pen]);
          tag = (line_mode == 2'd2) ? "R6/R11" : (line_mode == 2'd1) ? "R5/R11" : "R4/R11";
        end
        chk(int'(pix_color) == ex, tag, pix_color, ex);
        chk(pix_blank == (hs || vs), "R8 blank flag", pix_blank, int'(hs || vs));
        chk(chr_ready == (k == 15), "R10 ready at last", chr_ready, int'(k == 15));
        k++;
      end else begin
        chk(chr_ready == 1'b0, "R10 stall ready", chr_ready, 0);
      end
      @(negedge clk);
    end
    pix_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    load_pens();
    repeat (3) @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid", pix_valid, 0);
    chk(chr_ready == 1'b1, "R1 ready", chr_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R1 / R9: no line start, so reset mode 0 must apply despite scr_mode 2
    run_char(0, 2'd2, 1, 0, 0, 8'hA5, 8'h3C, 14'h0000, 3'd0, 7'd0, 0);
    run_char(1, 2'd3, 1, 0, 0, 8'h96, 8'hF0, 14'h3000, 3'd7, 7'd5, 0);   // R4 mode 3
    run_char(1, 2'd1, 1, 0, 0, 8'h81, 8'h5A, 14'h1234, 3'd3, 7'd9, 20);  // R5
    run_char(0, 2'd0, 1, 0, 0, 8'hC3, 8'h0F, 14'h1234, 3'd3, 7'd10, 20); // R9 held
    run_char(1, 2'd2, 1, 0, 0, 8'hB2, 8'h4D, 14'h03FF, 3'd1, 7'd1, 0);   // R6, offset wrap
    run_char(0, 2'd1, 0, 0, 0, 8'hFF, 8'hFF, 14'h2000, 3'd2, 7'd0, 40);  // R7
    run_char(0, 2'd1, 1, 1, 0, 8'hFF, 8'h00, 14'h0400, 3'd4, 7'd3, 40);  // R8 hsync
    run_char(0, 2'd1, 0, 0, 1, 8'h12, 8'h34, 14'h3FFF, 3'd7, 7'd127, 0); // R8 vsync
    for (int n = 0; n < 80; n++) begin
      if (n % 8 == 0) load_pens();
      run_char(($urandom % 4) == 0, 2'($urandom), ($urandom % 5) != 0,
               ($urandom % 10) == 0, ($urandom % 12) == 0,
               8'($urandom), 8'($urandom), 14'($urandom), 3'($urandom),
               7'($urandom), 30);
    end
    #1;
    chk(pix_valid == 1'b0, "R10 idle after last", pix_valid, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule